// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a 256-word by 18-bit first-in, first-out buffer between two free-running clocks. The clocks may be unrelated or identical. A producer on the write clock offers a word by raising one enable and lowering a second, inverted enable. The word is accepted only while the block reports that it has room. A consumer on the read clock sees the oldest word already sitting in an output register, and a valid flag marks it as present. The consumer removes that word only when its three active-low read qualifiers are all low.

The first word that enters an empty buffer moves to the output register by itself. The consumer does not need to request it. Two status flags run in the write-clock domain. One reports that more than half the storage is occupied. The other reports that the buffer is near either end, with a margin that software loads through the data input. A single asynchronous reset input clears both domains. Its release is synchronised separately in each domain.

Top module: `xclk_ft_fifo`

## Requirements
- R1: The buffer holds 256 words of 18 bits, and the word in the output register counts as one of them. After 256 accepted writes with no removals, `wr_ready_o` is low. Words leave in the order they were accepted.
- R2: A word is stored on a rising `wr_clk_i` edge only when `wr_en_hi_i` is 1, `wr_en_lo_n_i` is 0, `wr_ready_o` is 1 and `prog_n_i` is 1. Any other combination stores nothing.
- R3: A word is removed on a rising `rd_clk_i` edge only when `rd_en_n_i`, `oe1_n_i` and `oe2_n_i` are all 0 and `rd_valid_o` is 1. Otherwise `rd_valid_o` and `rd_data_o` hold their values, unless a first word falls through into an empty output register.
- R4: When the output register is empty and the storage holds a word, that word loads into `rd_data_o` and `rd_valid_o` rises, whatever the levels of the three read qualifiers.
- R5: `rst_i` is asynchronous and active high. While it is held for at least four edges of each clock, `wr_ready_o`, `rd_valid_o` and `half_full_o` read 0, and `near_lim_o` reads 1. Reset also returns the margin to its default of 32.
- R6: After `rst_i` falls, `wr_ready_o` rises no later than the third `wr_clk_i` edge. `rd_valid_o` stays 0 until a first word has fallen through.
- R7: `half_full_o` is 1 when the occupancy is greater than 128, and 0 otherwise. The value is seen in the write domain after the pointer-crossing latency.
- R8: `near_lim_o` is 1 when the occupancy is at most N or at least 256 − N. Otherwise it is 0.
- R9: On a `wr_clk_i` edge with `prog_n_i` at 0, N is loaded from `wr_data_i[7:0]`. That word is not stored.
- R10: Each pointer that crosses a clock domain is Gray-coded and changes by at most one bit per edge of its own clock. No word is lost or duplicated when the two sides run concurrently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Asynchronous reset, active high |
| wr_clk_i | input | 1 | Write clock |
| wr_en_hi_i | input | 1 | Write enable, active high |
| wr_en_lo_n_i | input | 1 | Write enable, active low |
| prog_n_i | input | 1 | Margin load strobe, active low |
| wr_data_i | input | 18 | Write data; low 8 bits carry N when loading |
| wr_ready_o | output | 1 | Room available, write-clock domain |
| rd_clk_i | input | 1 | Read clock |
| rd_en_n_i | input | 1 | Read enable, active low |
| oe1_n_i | input | 1 | First read qualifier, active low |
| oe2_n_i | input | 1 | Second read qualifier, active low |
| rd_data_o | output | 18 | Output register |
| rd_valid_o | output | 1 | Output register holds a word, read-clock domain |
| half_full_o | output | 1 | Occupancy above half |
| near_lim_o | output | 1 | Occupancy within N of empty or full |

## Verification
Two functions can fall on the same read-clock edge: removing the word in the output register, and refilling that register from storage. To provoke this, the bench holds all three read qualifiers low and streams a burst of consecutive writes. A fresh word is then taken on every read edge. The bench judges the result by comparing each observed word against an incrementing arithmetic sequence and counting the words. A repeated or skipped word shows up as a miscompare. A fill-and-drain sweep then walks the occupancy through every level from 0 to 256 and back, checking both flags against the arithmetic thresholds at each level.

// File: rtl/xff_pkg.sv
package xff_pkg;
   // lower bound on synchroniser depth
   localparam int unsigned XFF_MIN_STAGES = 2;
   // status flags produced in the write domain
   typedef struct packed {
      logic half;
      logic near_lim;
   } xff_flags_t;
endpackage

// File: rtl/xff_rst_sync.sv
module xff_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   output logic rst_n_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i) chain <= '0;
      else        chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain[STAGES-1];
endmodule

// File: rtl/xff_ptr_sync.sv
module xff_ptr_sync #(
   parameter int PW     = 9,
   parameter int STAGES = 2
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic [PW-1:0] gray_i,
   output logic [PW-1:0] bin_o
);
   logic [PW-1:0] stg [STAGES];
   logic [PW-1:0] g;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= gray_i;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign g = stg[STAGES-1];

   // each binary bit is the parity of the Gray bits at and above it
   generate
      for (genvar i = 0; i < PW; i++) begin : g_bit
         assign bin_o[i] = ^g[PW-1:i];
      end
   endgenerate
endmodule

// File: rtl/xff_ram.sv
module xff_ram #(
   parameter int AW = 8,
   parameter int DW = 18
) (
   input  logic          wclk_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk_i) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/xff_wr_ctl.sv
module xff_wr_ctl
   import xff_pkg::*;
#(
   parameter int AW      = 8,
   parameter int STAGES  = 2,
   parameter int THR_DEF = 32
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic          en_hi_i,
   input  logic          en_lo_n_i,
   input  logic          prog_n_i,
   input  logic [AW-1:0] prog_val_i,
   input  logic [AW:0]   cons_gray_i,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic [AW:0]   wr_gray_o,
   output logic          ready_o,
   output xff_flags_t    flags_o
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [PW-1:0] wbin, wbin_nxt, cbin, lvl_nxt, thr_ext;
   logic [AW-1:0] thr;
   logic          push;

   xff_ptr_sync #(.PW(PW), .STAGES(STAGES)) u_cons_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .gray_i  (cons_gray_i),
      .bin_o   (cbin)
   );

   assign push     = en_hi_i & ~en_lo_n_i & ready_o & prog_n_i;
   assign wbin_nxt = wbin + PW'(push);
   assign lvl_nxt  = wbin_nxt - cbin;
   assign thr_ext  = {1'b0, thr};

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         wbin              <= '0;
         wr_gray_o         <= '0;
         ready_o           <= 1'b0;
         flags_o.half      <= 1'b0;
         flags_o.near_lim  <= 1'b1;
         thr               <= AW'(THR_DEF);
      end else begin
         wbin              <= wbin_nxt;
         wr_gray_o         <= wbin_nxt ^ (wbin_nxt >> 1);
         ready_o           <= (lvl_nxt != PW'(DEPTH));
         flags_o.half      <= (lvl_nxt > PW'(DEPTH / 2));
         flags_o.near_lim  <= (lvl_nxt <= thr_ext) ||
                              (lvl_nxt >= (PW'(DEPTH) - thr_ext));
         if (!prog_n_i) thr <= prog_val_i;
      end
   end

   assign we_o    = push;
   assign waddr_o = wbin[AW-1:0];
endmodule

// File: rtl/xff_rd_ctl.sv
module xff_rd_ctl #(
   parameter int AW     = 8,
   parameter int DW     = 18,
   parameter int STAGES = 2
) (
   input  logic          clk_i,
   input  logic          rst_n_i,
   input  logic          rd_en_n_i,
   input  logic          oe1_n_i,
   input  logic          oe2_n_i,
   input  logic [AW:0]   wr_gray_i,
   input  logic [DW-1:0] mem_q_i,
   output logic [AW-1:0] raddr_o,
   output logic [DW-1:0] data_o,
   output logic          valid_o,
   output logic          avail_o,
   output logic [AW:0]   cons_gray_o
);
   localparam int PW = AW + 1;

   logic [PW-1:0] fbin, cbin, cbin_nxt, wbin_s;
   logic          pop, load;

   xff_ptr_sync #(.PW(PW), .STAGES(STAGES)) u_wr_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .gray_i  (wr_gray_i),
      .bin_o   (wbin_s)
   );

   assign avail_o  = (fbin != wbin_s);
   assign pop      = valid_o & ~rd_en_n_i & ~oe1_n_i & ~oe2_n_i;
   assign load     = avail_o & (~valid_o | pop);
   assign cbin_nxt = cbin + PW'(pop);
   assign raddr_o  = fbin[AW-1:0];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         fbin        <= '0;
         cbin        <= '0;
         cons_gray_o <= '0;
         data_o      <= '0;
         valid_o     <= 1'b0;
      end else begin
         cbin        <= cbin_nxt;
         cons_gray_o <= cbin_nxt ^ (cbin_nxt >> 1);
         if (load) begin
            data_o  <= mem_q_i;
            fbin    <= fbin + PW'(1);
            valid_o <= 1'b1;
         end else if (pop) begin
            valid_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/xclk_ft_fifo.sv
module xclk_ft_fifo
   import xff_pkg::*;
#(
   parameter int DATA_W   = 18,
   parameter int ADDR_W   = 8,
   parameter int SYNC_STG = 2,
   parameter int THR_DEF  = 32
) (
   input  logic              rst_i,
   input  logic              wr_clk_i,
   input  logic              wr_en_hi_i,
   input  logic              wr_en_lo_n_i,
   input  logic              prog_n_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              wr_ready_o,
   input  logic              rd_clk_i,
   input  logic              rd_en_n_i,
   input  logic              oe1_n_i,
   input  logic              oe2_n_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              half_full_o,
   output logic              near_lim_o
);
   localparam int PW = ADDR_W + 1;

   initial begin
      assert (SYNC_STG >= int'(XFF_MIN_STAGES))
         else $error("SYNC_STG below minimum");
      assert (DATA_W >= ADDR_W)
         else $error("DATA_W must carry the margin value");
      assert (ADDR_W >= 2 && THR_DEF >= 0 && THR_DEF < (1 << ADDR_W))
         else $error("ADDR_W or THR_DEF out of range");
   end

   logic              wr_rst_n, rd_rst_n, we, rd_avail;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PW-1:0]     wr_gray, cons_gray;
   logic [DATA_W-1:0] mem_q;
   xff_flags_t        flags;

   xff_rst_sync #(.STAGES(SYNC_STG)) u_wr_rst (
      .clk_i (wr_clk_i), .arst_i (rst_i), .rst_n_o (wr_rst_n)
   );
   xff_rst_sync #(.STAGES(SYNC_STG)) u_rd_rst (
      .clk_i (rd_clk_i), .arst_i (rst_i), .rst_n_o (rd_rst_n)
   );

   xff_wr_ctl #(.AW(ADDR_W), .STAGES(SYNC_STG), .THR_DEF(THR_DEF)) u_wr (
      .clk_i       (wr_clk_i),
      .rst_n_i     (wr_rst_n),
      .en_hi_i     (wr_en_hi_i),
      .en_lo_n_i   (wr_en_lo_n_i),
      .prog_n_i    (prog_n_i),
      .prog_val_i  (wr_data_i[ADDR_W-1:0]),
      .cons_gray_i (cons_gray),
      .we_o        (we),
      .waddr_o     (waddr),
      .wr_gray_o   (wr_gray),
      .ready_o     (wr_ready_o),
      .flags_o     (flags)
   );

   xff_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
      .wclk_i  (wr_clk_i),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wr_data_i),
      .raddr_i (raddr),
      .rdata_o (mem_q)
   );

   xff_rd_ctl #(.AW(ADDR_W), .DW(DATA_W), .STAGES(SYNC_STG)) u_rd (
      .clk_i       (rd_clk_i),
      .rst_n_i     (rd_rst_n),
      .rd_en_n_i   (rd_en_n_i),
      .oe1_n_i     (oe1_n_i),
      .oe2_n_i     (oe2_n_i),
      .wr_gray_i   (wr_gray),
      .mem_q_i     (mem_q),
      .raddr_o     (raddr),
      .data_o      (rd_data_o),
      .valid_o     (rd_valid_o),
      .avail_o     (rd_avail),
      .cons_gray_o (cons_gray)
   );

   assign half_full_o = flags.half;
   assign near_lim_o  = flags.near_lim;
endmodule

// File: rtl/xff_chk.sv
module xff_chk #(
   parameter int PW = 9,
   parameter int DW = 18
) (
   input logic          rst_i,
   input logic          wr_clk_i,
   input logic          rd_clk_i,
   input logic          wr_en_hi_i,
   input logic          wr_en_lo_n_i,
   input logic          prog_n_i,
   input logic          wr_ready_o,
   input logic          rd_en_n_i,
   input logic          oe1_n_i,
   input logic          oe2_n_i,
   input logic [DW-1:0] rd_data_o,
   input logic          rd_valid_o,
   input logic          half_full_o,
   input logic          near_lim_o,
   input logic          rd_avail,
   input logic [PW-1:0] wr_gray,
   input logic [PW-1:0] cons_gray
);
   logic [1:0] wcnt = '0;
   logic [1:0] rcnt = '0;

   always @(posedge wr_clk_i) begin
      if (rst_i && wcnt >= 2'd2)
         p_reset_wflags_r5: assert (!wr_ready_o && !half_full_o && near_lim_o);
      wcnt <= !rst_i ? 2'd0 : (wcnt == 2'd3 ? 2'd3 : wcnt + 2'd1);
   end

   always @(posedge rd_clk_i) begin
      if (rst_i && rcnt >= 2'd2)
         p_reset_rflags_r5: assert (!rd_valid_o);
      rcnt <= !rst_i ? 2'd0 : (rcnt == 2'd3 ? 2'd3 : rcnt + 2'd1);
   end

   p_no_overflow_r1: assert property (@(posedge wr_clk_i) disable iff (rst_i)
      !wr_ready_o |=> $stable(wr_gray));

   p_write_qual_r2: assert property (@(posedge wr_clk_i) disable iff (rst_i)
      (!wr_en_hi_i || wr_en_lo_n_i || !prog_n_i) |=> $stable(wr_gray));

   p_no_underflow_r3: assert property (@(posedge rd_clk_i) disable iff (rst_i)
      !rd_valid_o |=> $stable(cons_gray));

   p_hold_r3: assert property (@(posedge rd_clk_i) disable iff (rst_i)
      (rd_valid_o && (rd_en_n_i || oe1_n_i || oe2_n_i)) |=>
      (rd_valid_o && $stable(rd_data_o)));

   p_fall_through_r4: assert property (@(posedge rd_clk_i) disable iff (rst_i)
      (!rd_valid_o && rd_avail) |=> rd_valid_o);

   p_gray_wr_r10: assert property (@(posedge wr_clk_i) disable iff (rst_i)
      1'b1 |=> ($countones(wr_gray ^ $past(wr_gray)) <= 1));

   p_gray_rd_r10: assert property (@(posedge rd_clk_i) disable iff (rst_i)
      1'b1 |=> ($countones(cons_gray ^ $past(cons_gray)) <= 1));
endmodule

bind xclk_ft_fifo xff_chk #(.PW(ADDR_W + 1), .DW(DATA_W)) u_chk (
   .rst_i        (rst_i),
   .wr_clk_i     (wr_clk_i),
   .rd_clk_i     (rd_clk_i),
   .wr_en_hi_i   (wr_en_hi_i),
   .wr_en_lo_n_i (wr_en_lo_n_i),
   .prog_n_i     (prog_n_i),
   .wr_ready_o   (wr_ready_o),
   .rd_en_n_i    (rd_en_n_i),
   .oe1_n_i      (oe1_n_i),
   .oe2_n_i      (oe2_n_i),
   .rd_data_o    (rd_data_o),
   .rd_valid_o   (rd_valid_o),
   .half_full_o  (half_full_o),
   .near_lim_o   (near_lim_o),
   .rd_avail     (rd_avail),
   .wr_gray      (wr_gray),
   .cons_gray    (cons_gray)
);

// File: tb/tb_xclk_ft_fifo.sv
module tb_xclk_ft_fifo;
   logic        wclk = 0, rclk = 0, rst = 1;
   logic        hi = 0, lon = 1, pn = 1, ren = 1, oe1 = 1, oe2 = 1;
   logic [17:0] wd = '0;
   logic        wready, rvalid, half, nlim;
   logic [17:0] rdata;
   int          vectors = 0, fails = 0, occ = 0;
   bit          done = 0;

   xclk_ft_fifo dut (
      .rst_i (rst), .wr_clk_i (wclk), .wr_en_hi_i (hi), .wr_en_lo_n_i (lon),
      .prog_n_i (pn), .wr_data_i (wd), .wr_ready_o (wready),
      .rd_clk_i (rclk), .rd_en_n_i (ren), .oe1_n_i (oe1), .oe2_n_i (oe2),
      .rd_data_o (rdata), .rd_valid_o (rvalid),
      .half_full_o (half), .near_lim_o (nlim)
   );

   always #4 wclk = ~wclk;
   initial begin #3; forever #4 rclk = ~rclk; end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr_raw(input logic h, input logic l, input logic p, input logic [17:0] d);
      @(posedge wclk); #1; hi = h; lon = l; pn = p; wd = d;
      @(posedge wclk); #1; hi = 0; lon = 1; pn = 1;
   endtask

   task automatic settle();
      repeat (10) @(posedge wclk);
      #1;
   endtask

   task automatic pop();
      @(posedge rclk); #1; ren = 0; oe1 = 0; oe2 = 0;
      @(posedge rclk); #1; ren = 1; oe1 = 1; oe2 = 1;
   endtask

   task automatic flags(input int n);
      bit eh, en;
      eh = (occ > 128);
      en = (occ <= n) || (occ >= 256 - n);
      check(half == eh, "R7 half_full", int'(half), int'(eh));
      check(nlim == en, "R8 near_lim", int'(nlim), int'(en));
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int edges, got;
      // R5: values during reset
      repeat (5) @(posedge wclk);
      #1;
      check(wready == 0, "R5 wr_ready in reset", int'(wready), 0);
      check(rvalid == 0, "R5 rd_valid in reset", int'(rvalid), 0);
      check(half == 0, "R5 half in reset", int'(half), 0);
      check(nlim == 1, "R5 near_lim in reset", int'(nlim), 1);
      rst = 0;
      edges = 0;
      for (int i = 0; i < 6; i++) begin
         @(posedge wclk); #1; edges++;
         if (wready) break;
      end
      check(edges <= 3 && wready, "R6 ready after release", edges, 3);
      check(rvalid == 0, "R6 rd_valid before data", int'(rvalid), 0);

      // R2: disqualified writes; R9: program word with N=32 not stored
      wr_raw(1, 1, 1, 18'h11);
      wr_raw(0, 0, 1, 18'h22);
      wr_raw(0, 1, 1, 18'h33);
      wr_raw(1, 0, 0, 18'd32);
      settle();
      check(rvalid == 0, "R2 R9 nothing stored", int'(rvalid), 0);
      flags(32);

      // R4: fall-through with read qualifiers inactive
      wr_raw(1, 0, 1, 18'h2A5A5); occ = 1;
      settle();
      check(rvalid == 1, "R4 fall-through valid", int'(rvalid), 1);
      check(rdata == 18'h2A5A5, "R4 fall-through data", int'(rdata), 'h2A5A5);

      // R3: every qualifier combination except all-low holds the word
      for (int c = 1; c < 8; c++) begin
         @(posedge rclk); #1; ren = c[0]; oe1 = c[1]; oe2 = c[2];
         repeat (3) @(posedge rclk);
         #1;
         check(rvalid == 1 && rdata == 18'h2A5A5, "R3 hold", int'(rdata), 'h2A5A5);
         ren = 1; oe1 = 1; oe2 = 1;
      end
      pop(); occ = 0;
      settle();
      check(rvalid == 0, "R3 removed", int'(rvalid), 0);

      // R1 R7 R8: fill sweep
      for (int k = 0; k < 300; k++) begin
         @(posedge wclk); #1;
         if (!wready) break;
         wr_raw(1, 0, 1, 18'(k)); occ++;
         settle();
         flags(32);
      end
      check(occ == 256, "R1 capacity", occ, 256);
      wr_raw(1, 0, 1, 18'h3FFFF);
      settle();
      check(wready == 0, "R1 full ready low", int'(wready), 0);

      // R1 R7 R8: drain sweep, order
      for (int k = 0; k < 256; k++) begin
         check(rvalid == 1 && rdata == 18'(k), "R1 order", int'(rdata), k);
         pop(); occ--;
         settle();
         flags(32);
      end
      check(rvalid == 0, "R1 empty after drain", int'(rvalid), 0);

      // R9: margin 16
      wr_raw(1, 0, 0, 18'd16);
      settle();
      check(rvalid == 0, "R9 program word not stored", int'(rvalid), 0);
      for (int k = 0; k < 20; k++) begin
         wr_raw(1, 0, 1, 18'(1000 + k)); occ++;
         settle();
         flags(16);
      end
      for (int k = 0; k < 20; k++) begin
         check(rdata == 18'(1000 + k), "R9 data order", int'(rdata), 1000 + k);
         pop(); occ--;
      end
      settle();

      // R10: streaming, pop and refill on the same read edge
      @(posedge rclk); #1; ren = 0; oe1 = 0; oe2 = 0;
      got = 0;
      fork
         begin
            @(posedge wclk); #1; hi = 1; lon = 0;
            for (int i = 0; i < 60; i++) begin
               wd = 18'(5000 + i);
               @(posedge wclk); #1;
            end
            hi = 0; lon = 1;
         end
         begin
            for (int t = 0; t < 400 && got < 60; t++) begin
               @(posedge rclk); #1;
               if (rvalid) begin
                  check(rdata == 18'(5000 + got), "R10 stream order", int'(rdata), 5000 + got);
                  got++;
               end
            end
         end
      join
      ren = 1; oe1 = 1; oe2 = 1;
      check(got == 60, "R10 stream count", got, 60);
      settle();

      // R5: mid-run reset restores margin 32
      for (int k = 0; k < 5; k++) wr_raw(1, 0, 1, 18'(k));
      rst = 1;
      repeat (6) @(posedge wclk);
      #1;
      check(wready == 0 && half == 0 && nlim == 1, "R5 mid-run reset flags", int'(wready), 0);
      check(rvalid == 0, "R5 mid-run reset rd_valid", int'(rvalid), 0);
      rst = 0; occ = 0;
      settle();
      check(rvalid == 0, "R6 empty after reset", int'(rvalid), 0);
      for (int k = 0; k < 34; k++) begin
         wr_raw(1, 0, 1, 18'(k)); occ++;
         if (occ >= 31) begin
            settle();
            flags(32);
         end
      end

      done = 1;
      summary();
      $finish;
   end
endmodule